// File: doc/BRIEF.md
# Halt Power Sequencer

This block controls how a small microcontroller core enters and leaves its deepest low-power halt state. When the core executes a halt instruction it raises a one-cycle strobe. The block then either stops the oscillator, the peripheral clocks and the CPU clock, or turns the request into a watchdog reset. Which of the two happens depends on a watchdog-in-halt option bit. If the auto-wake-up enable is set, the strobe belongs to a separate active-halt path and this block leaves it alone.

While halted, only a wake-capable interrupt or a reset request can bring the core back. On wake-up the oscillator restarts at once. The CPU and peripheral clocks stay gated for a stabilisation window of 256 or 4096 CPU clock cycles, chosen by a static select input. When the window ends the clocks come back, and a one-cycle flag tells the core whether to fetch the reset vector or to service the waking interrupt. The block also owns the interrupt-mask bit. It clears the bit on halt entry, sets it for the interrupt service, and restores the saved value when the core pops its condition state. All control pins are plain level or strobe signals; there is no data stream.

Top module: `pwr_halt_seq`

## Requirements
- R1: After reset, osc_en, periph_clk_en and cpu_clk_en are 1, irq_mask is 1, and wdg_rst_req, fetch_rst_vec and svc_irq are 0.
- R2: While awu_en is 1, a halt_req strobe changes no output: the clocks stay enabled and no watchdog reset is requested.
- R3: With awu_en 0 and wdg_opt 1, a halt_req strobe in the running state makes wdg_rst_req 1 for exactly the one cycle after the sampling edge. All clock enables stay 1.
- R4: With awu_en 0 and wdg_opt 0, all three clock enables go to 0 and irq_mask goes to 0 at the edge that samples halt_req. Every enable is a flop output.
- R5: While halted, only wake_irq or rst_req can change the outputs. halt_req, awu_en, wdg_opt and iret_pop are ignored.
- R6: A wake event sets osc_en to 1 at the edge that samples it. cpu_clk_en and periph_clk_en then stay 0 for exactly 256 cycles if long_dly_sel is 0, or 4096 cycles if it is 1, before they return to 1.
- R7: In the first cycle the clocks are back, exactly one of svc_irq (wake by interrupt) or fetch_rst_vec (wake by reset) is 1, for one cycle only.
- R8: When svc_irq is asserted, irq_mask is 1. A later iret_pop strobe in the running state restores irq_mask to the value it had before service, which is 0 after a halt. After a reset wake, irq_mask is 1.
- R9: If rst_req and wake_irq are both 1 on the waking edge, the resume path is the reset-vector fetch.
- R10: An rst_req during the stabilisation window restarts the full window from that edge and forces the resume path to the reset-vector fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock domain clock (the free-running source ahead of the gates) |
| rst_n | input | 1 | Asynchronous active-low system reset |
| halt_req | input | 1 | One-cycle strobe from a halt instruction |
| awu_en | input | 1 | Auto-wake-up enable; 1 routes halt to the active-halt path elsewhere |
| wdg_opt | input | 1 | Watchdog-in-halt option; 1 turns halt into a watchdog reset |
| wake_irq | input | 1 | Wake-capable interrupt request |
| rst_req | input | 1 | Reset request acting as a wake source |
| long_dly_sel | input | 1 | Static select: 0 gives 256 cycles, 1 gives 4096 cycles of stabilisation |
| iret_pop | input | 1 | Strobe: saved condition state popped at the end of interrupt service |
| osc_en | output | 1 | Oscillator enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| wdg_rst_req | output | 1 | One-cycle watchdog reset request |
| fetch_rst_vec | output | 1 | One-cycle flag: resume by fetching the reset vector |
| svc_irq | output | 1 | One-cycle flag: resume by servicing the waking interrupt |
| irq_mask | output | 1 | Interrupt mask bit |

## Verification
The bench builds the block with its default window lengths of 256 and 4096 cycles, so the measured gap between the oscillator restart and the clock return is compared with the real counts and not with scaled-down ones. Both lengths fit well inside the run time. This covers the full-width counter limit on the long window and the terminal count on the short one. It also covers a reset that arrives deep in the window and restarts it.

// File: rtl/pwr_halt_pkg.sv
package pwr_halt_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_HALT   = 2'd1,
    ST_WAKE   = 2'd2,
    ST_RESUME = 2'd3
  } hs_state_e;
endpackage

// File: rtl/hs_wake_timer.sv
module hs_wake_timer #(
  parameter int SHORT_DLY = 256,
  parameter int LONG_DLY  = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  input  logic sel_long,
  output logic done
);
  localparam int CW = $clog2(LONG_DLY);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim_q;

  // The limit is latched at every (re)load so the window cannot shift mid-count.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= CW'(SHORT_DLY - 1);
    end else if (load) begin
      cnt_q <= '0;
      lim_q <= sel_long ? CW'(LONG_DLY - 1) : CW'(SHORT_DLY - 1);
    end else if (run) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done = run && (cnt_q == lim_q);
endmodule

// File: rtl/hs_fsm.sv
module hs_fsm
  import pwr_halt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      halt_req,
  input  logic      awu_en,
  input  logic      wdg_opt,
  input  logic      wake_irq,
  input  logic      rst_req,
  input  logic      dly_done,
  output hs_state_e state_q,
  output hs_state_e state_d,
  output logic      tmr_load,
  output logic      tmr_run,
  output logic      enter_halt,
  output logic      wdg_fire,
  output logic      src_rst_q
);
  logic src_rst_d;

  always_comb begin
    state_d    = state_q;
    tmr_load   = 1'b0;
    enter_halt = 1'b0;
    wdg_fire   = 1'b0;
    src_rst_d  = src_rst_q;
    unique case (state_q)
      ST_RUN: begin
        if (halt_req && !awu_en) begin
          if (wdg_opt) begin
            wdg_fire = 1'b1;
          end else begin
            state_d    = ST_HALT;
            enter_halt = 1'b1;
          end
        end
      end
      ST_HALT: begin
        if (rst_req || wake_irq) begin
          state_d   = ST_WAKE;
          tmr_load  = 1'b1;
          src_rst_d = rst_req;        // reset wins a tie
        end
      end
      ST_WAKE: begin
        if (rst_req) begin
          tmr_load  = 1'b1;           // restart the window
          src_rst_d = 1'b1;
        end else if (dly_done) begin
          state_d = ST_RESUME;
        end
      end
      ST_RESUME: begin
        state_d = ST_RUN;
      end
      default: state_d = ST_RUN;
    endcase
  end

  assign tmr_run = (state_q == ST_WAKE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_RUN;
      src_rst_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      src_rst_q <= src_rst_d;
    end
  end
endmodule

// File: rtl/hs_out_regs.sv
module hs_out_regs
  import pwr_halt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  hs_state_e state_d,
  input  logic      src_rst,
  input  logic      wdg_fire,
  output logic      osc_en,
  output logic      periph_clk_en,
  output logic      cpu_clk_en,
  output logic      wdg_rst_req,
  output logic      fetch_rst_vec,
  output logic      svc_irq
);
  logic core_on;
  logic resuming;

  assign core_on  = (state_d == ST_RUN) || (state_d == ST_RESUME);
  assign resuming = (state_d == ST_RESUME);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osc_en        <= 1'b1;
      periph_clk_en <= 1'b1;
      cpu_clk_en    <= 1'b1;
      wdg_rst_req   <= 1'b0;
      fetch_rst_vec <= 1'b0;
      svc_irq       <= 1'b0;
    end else begin
      osc_en        <= (state_d != ST_HALT);
      periph_clk_en <= core_on;
      cpu_clk_en    <= core_on;
      wdg_rst_req   <= wdg_fire;
      fetch_rst_vec <= resuming && src_rst;
      svc_irq       <= resuming && !src_rst;
    end
  end
endmodule

// File: rtl/hs_irq_mask.sv
module hs_irq_mask
  import pwr_halt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  hs_state_e state_q,
  input  hs_state_e state_d,
  input  logic      enter_halt,
  input  logic      src_rst,
  input  logic      iret_pop,
  output logic      irq_mask
);
  logic saved_q;
  logic to_resume;

  assign to_resume = (state_q == ST_WAKE) && (state_d == ST_RESUME);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_mask <= 1'b1;
      saved_q  <= 1'b1;
    end else if (enter_halt) begin
      irq_mask <= 1'b0;
    end else if (to_resume) begin
      irq_mask <= 1'b1;
      saved_q  <= src_rst ? 1'b1 : irq_mask;
    end else if (iret_pop && (state_q == ST_RUN)) begin
      irq_mask <= saved_q;
    end
  end
endmodule

// File: rtl/pwr_halt_seq.sv
module pwr_halt_seq
  import pwr_halt_pkg::*;
#(
  parameter int SHORT_DLY = 256,
  parameter int LONG_DLY  = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic halt_req,
  input  logic awu_en,
  input  logic wdg_opt,
  input  logic wake_irq,
  input  logic rst_req,
  input  logic long_dly_sel,
  input  logic iret_pop,
  output logic osc_en,
  output logic periph_clk_en,
  output logic cpu_clk_en,
  output logic wdg_rst_req,
  output logic fetch_rst_vec,
  output logic svc_irq,
  output logic irq_mask
);
  hs_state_e st_q, st_d;
  logic tmr_load, tmr_run, tmr_done;
  logic enter_halt, wdg_fire, src_rst;

  hs_wake_timer #(.SHORT_DLY(SHORT_DLY), .LONG_DLY(LONG_DLY)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .run      (tmr_run),
    .sel_long (long_dly_sel),
    .done     (tmr_done)
  );

  hs_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .halt_req   (halt_req),
    .awu_en     (awu_en),
    .wdg_opt    (wdg_opt),
    .wake_irq   (wake_irq),
    .rst_req    (rst_req),
    .dly_done   (tmr_done),
    .state_q    (st_q),
    .state_d    (st_d),
    .tmr_load   (tmr_load),
    .tmr_run    (tmr_run),
    .enter_halt (enter_halt),
    .wdg_fire   (wdg_fire),
    .src_rst_q  (src_rst)
  );

  hs_out_regs u_out (
    .clk           (clk),
    .rst_n         (rst_n),
    .state_d       (st_d),
    .src_rst       (src_rst),
    .wdg_fire      (wdg_fire),
    .osc_en        (osc_en),
    .periph_clk_en (periph_clk_en),
    .cpu_clk_en    (cpu_clk_en),
    .wdg_rst_req   (wdg_rst_req),
    .fetch_rst_vec (fetch_rst_vec),
    .svc_irq       (svc_irq)
  );

  hs_irq_mask u_mask (
    .clk        (clk),
    .rst_n      (rst_n),
    .state_q    (st_q),
    .state_d    (st_d),
    .enter_halt (enter_halt),
    .src_rst    (src_rst),
    .iret_pop   (iret_pop),
    .irq_mask   (irq_mask)
  );
endmodule

// File: rtl/pwr_halt_seq_chk.sv
module pwr_halt_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic halt_req,
  input logic awu_en,
  input logic wdg_opt,
  input logic wake_irq,
  input logic rst_req,
  input logic long_dly_sel,
  input logic iret_pop,
  input logic osc_en,
  input logic periph_clk_en,
  input logic cpu_clk_en,
  input logic wdg_rst_req,
  input logic fetch_rst_vec,
  input logic svc_irq,
  input logic irq_mask
);
  assert_awu_ignore_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en && halt_req && awu_en) |=> (cpu_clk_en && !wdg_rst_req));

  assert_wdg_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en && !fetch_rst_vec && !svc_irq && halt_req && !awu_en && wdg_opt)
      |=> (wdg_rst_req && cpu_clk_en && osc_en));

  assert_halt_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |-> (!irq_mask && !cpu_clk_en && !periph_clk_en));

  assert_stay_halted_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_en && !wake_irq && !rst_req) |=> (!osc_en && !cpu_clk_en));

  assert_wake_osc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_en && (wake_irq || rst_req)) |=> (osc_en && !cpu_clk_en));

  assert_cpu_needs_osc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clk_en |-> osc_en);

  assert_one_resume_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(fetch_rst_vec && svc_irq));

  assert_resume_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_clk_en) |-> (fetch_rst_vec || svc_irq));

  assert_svc_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    svc_irq |-> irq_mask);

  assert_rst_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_en && !cpu_clk_en && rst_req) |=> !cpu_clk_en);
endmodule

bind pwr_halt_seq pwr_halt_seq_chk u_chk (.*);

// File: tb/test_pwr_halt_seq.sv
module test_pwr_halt_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic halt_req = 0, awu_en = 0, wdg_opt = 0, wake_irq = 0, rst_req = 0;
  logic long_dly_sel = 0, iret_pop = 0;
  logic osc_en, periph_clk_en, cpu_clk_en, wdg_rst_req, fetch_rst_vec, svc_irq, irq_mask;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;   // 250 MHz

  pwr_halt_seq i_pwr_halt_seq (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .awu_en(awu_en),
    .wdg_opt(wdg_opt), .wake_irq(wake_irq), .rst_req(rst_req),
    .long_dly_sel(long_dly_sel), .iret_pop(iret_pop),
    .osc_en(osc_en), .periph_clk_en(periph_clk_en), .cpu_clk_en(cpu_clk_en),
    .wdg_rst_req(wdg_rst_req), .fetch_rst_vec(fetch_rst_vec),
    .svc_irq(svc_irq), .irq_mask(irq_mask)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // enables packed as {osc, periph, cpu}
  function automatic int ens();
    return {29'd0, osc_en, periph_clk_en, cpu_clk_en};
  endfunction

  task automatic do_halt();
    halt_req = 1; tick(); halt_req = 0;
  endtask

  // Count cycles with the core clock gated after the wake edge.
  task automatic count_gap(output int n);
    n = 0;
    while (!cpu_clk_en && n < 5000) begin
      tick(); n++;
    end
  endtask

  task automatic t_reset();
    chk("R1", "enables", ens(), 7);
    chk("R1", "irq_mask", irq_mask, 1);
    chk("R1", "pulses", {wdg_rst_req, fetch_rst_vec, svc_irq}, 0);
  endtask

  task automatic t_awu();
    awu_en = 1; wdg_opt = 0;
    do_halt();
    chk("R2", "enables after halt awu", ens(), 7);
    chk("R2", "wdg", wdg_rst_req, 0);
    tick();
    chk("R2", "enables later", ens(), 7);
    awu_en = 1; wdg_opt = 1;
    do_halt();
    chk("R2", "wdg with opt", wdg_rst_req, 0);
    awu_en = 0; wdg_opt = 0;
  endtask

  task automatic t_wdg();
    wdg_opt = 1;
    do_halt();
    chk("R3", "wdg pulse", wdg_rst_req, 1);
    chk("R3", "enables", ens(), 7);
    tick();
    chk("R3", "wdg cleared", wdg_rst_req, 0);
    chk("R3", "enables after", ens(), 7);
    wdg_opt = 0;
  endtask

  task automatic t_wake_irq(input logic sel, input int exp_gap);
    int n;
    long_dly_sel = sel;
    do_halt();
    chk("R4", "enables off", ens(), 0);
    chk("R4", "mask cleared", irq_mask, 0);
    // R5: other stimulus while halted has no effect
    halt_req = 1; awu_en = 1; wdg_opt = 1; iret_pop = 1;
    tick(); tick();
    halt_req = 0; awu_en = 0; wdg_opt = 0; iret_pop = 0;
    tick();
    chk("R5", "still halted", ens(), 0);
    chk("R5", "mask held", irq_mask, 0);
    chk("R5", "no wdg", wdg_rst_req, 0);
    wake_irq = 1; tick(); wake_irq = 0;
    chk("R6", "osc on at wake", ens(), 4);
    count_gap(n);
    chk("R6", "gap cycles", n, exp_gap);
    chk("R6", "clocks back", ens(), 7);
    chk("R7", "svc flag", svc_irq, 1);
    chk("R7", "fetch flag", fetch_rst_vec, 0);
    chk("R8", "mask in service", irq_mask, 1);
    tick();
    chk("R7", "svc one cycle", svc_irq, 0);
    iret_pop = 1; tick(); iret_pop = 0;
    chk("R8", "mask restored", irq_mask, 0);
    long_dly_sel = 0;
  endtask

  task automatic t_wake_rst(input logic both);
    int n;
    do_halt();
    rst_req = 1; wake_irq = both; tick(); rst_req = 0; wake_irq = 0;
    count_gap(n);
    chk(both ? "R9" : "R7", "gap", n, 256);
    chk(both ? "R9" : "R7", "fetch flag", fetch_rst_vec, 1);
    chk(both ? "R9" : "R7", "svc flag", svc_irq, 0);
    chk("R8", "mask after reset wake", irq_mask, 1);
    tick();
    chk("R7", "fetch one cycle", fetch_rst_vec, 0);
  endtask

  task automatic t_rst_in_window();
    int n;
    do_halt();
    wake_irq = 1; tick(); wake_irq = 0;
    repeat (100) tick();
    chk("R10", "still gated", cpu_clk_en, 0);
    rst_req = 1; tick(); rst_req = 0;
    count_gap(n);
    chk("R10", "restarted gap", n, 256);
    chk("R10", "fetch flag", fetch_rst_vec, 1);
    chk("R10", "svc flag", svc_irq, 0);
    tick();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tick();
    t_reset();
    t_awu();
    t_wdg();
    t_wake_irq(1'b0, 256);
    t_wake_irq(1'b1, 4096);
    t_wake_rst(1'b0);
    t_wake_rst(1'b1);
    t_rst_in_window();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog run did not finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule